// File: doc/BRIEF.md
# I2C Register-Access Transaction Sequencer

This block runs whole register-style transactions against one addressed device on an I2C bus. It does not drive the wires itself. It sits above a bit-level engine and issues that engine four kinds of command: bus start, bus stop, write one byte, and read one byte. It then uses the acknowledge bit or the data byte that the engine returns. One request carries the operation (write, read or probe), a 7-bit device address, a register pointer of zero to four bytes with its length, an optional pointer-overflow mask, a choice between stop-then-start and a repeated start before the read phase, and a byte count. Payload enters on a valid/ready write port and leaves on a valid/ready read port.

Each phase handles a missing acknowledge in its own way. A device that does not answer its address ends the transaction at once with a stop. A register-pointer byte that is not acknowledged also ends it, with a separate status code. A write data byte that is not acknowledged does not stop the transfer: the remaining bytes are still sent and the misses are counted. When the closing stop completes, the block raises a one-cycle completion pulse. Its status code and failure count stay fixed until the next completion.

Top module: `i2c_xact_seq`

## Requirements
- R1: The first byte written after each bus start is the device address in bits 7:1. Bit 0 is 0 for the pointer or write phase and 1 for the read phase. Command codes on `cmd_o` are 0 start, 1 stop, 2 write byte, 3 read byte.
- R2: After the write-phase address byte, the block writes exactly `req_alen_i` pointer bytes, the most significant first, taken from the low `8*req_alen_i` bits of `req_addr_i`. Length values above 4 act as 4.
- R3: A read (`req_op_i`=1) with pointer length 0 has no pointer phase. The sequence is start, then the read-phase address byte.
- R4: In a read, when the pointer bytes are done, the block issues stop then start if `req_rstart_i`=0, and only a start if `req_rstart_i`=1.
- R5: A read of N bytes issues N read commands. `cmd_ack_o` is 0 (acknowledge) on all of them except the last, where it is 1. A stop follows. Bytes leave on `rd_data_o` in order, and each waits for `rd_ready_i`.
- R6: If the device address byte is not acknowledged, in either phase, the block issues a stop next and finishes with status 1 (no device).
- R7: If a pointer byte is not acknowledged, the block issues a stop next and finishes with status 2 (pointer rejected).
- R8: In a write (`req_op_i`=0), a data byte that is not acknowledged does not stop the transfer. All N bytes from the write port are sent, then a stop. The status is 0 and `fail_cnt_o` equals the number of unacknowledged data bytes.
- R9: A probe (`req_op_i`=2, and code 3 also acts as probe) is start, address byte with bit 0 clear, stop. It finishes with status 0 if the device acknowledged and status 1 if it did not.
- R10: The device address sent is `req_chip_i` OR (bits 6:0 of `req_addr_i` shifted right by `8*length`, ANDed with `req_ovf_mask_i`).
- R11: `done_o` lasts exactly one cycle after the closing stop completes. `status_o` and `fail_cnt_o` change only in that cycle and hold until the next completion.
- R12: After reset the block is idle. `req_ready_o` is 1, no command or read byte is offered, `done_o` is 0, and status and count are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle, request accepted |
| req_op_i | input | 2 | 0 write, 1 read, 2/3 probe |
| req_chip_i | input | 7 | Device address |
| req_addr_i | input | 8*ADDR_BYTES | Register pointer value |
| req_alen_i | input | clog2(ADDR_BYTES+1) | Pointer length in bytes |
| req_len_i | input | LEN_W | Payload byte count |
| req_rstart_i | input | 1 | 1: repeated start only before read phase |
| req_ovf_mask_i | input | 7 | Pointer overflow bits folded into device address |
| wr_valid_i | input | 1 | Write byte available |
| wr_data_i | input | 8 | Write byte |
| wr_ready_o | output | 1 | Write byte taken |
| rd_valid_o | output | 1 | Read byte available |
| rd_data_o | output | 8 | Read byte |
| rd_ready_i | input | 1 | Read byte taken |
| cmd_valid_o | output | 1 | Command offered to bit engine |
| cmd_ready_i | input | 1 | Bit engine takes command |
| cmd_o | output | 2 | Command code |
| cmd_byte_o | output | 8 | Byte for write command |
| cmd_ack_o | output | 1 | Acknowledge level to drive after a read byte |
| rsp_valid_i | input | 1 | Bit engine finished current command |
| rsp_nack_i | input | 1 | Written byte was not acknowledged |
| rsp_data_i | input | 8 | Byte received by read command |
| done_o | output | 1 | Completion pulse |
| status_o | output | 2 | 0 ok, 1 no device, 2 pointer rejected |
| fail_cnt_o | output | LEN_W | Unacknowledged write data bytes |

## Verification
The hardest case to reach is a miss in the middle of a sequence: a refusal on one chosen pointer byte, or on the read-phase address byte after a complete pointer phase. From the ports this looks the same as an ordinary transaction. The bench's bit-engine model numbers every write command in a transaction and refuses the ones marked in a per-transaction mask. Its reference model walks the same mask to predict where the stop must come and which status code follows. Ready signals that pause the engine and the read sink on fixed cycle patterns check that handshakes held open do not disturb that sequence.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_STOP  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_READ  = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_PROBE = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    ST_OK        = 2'd0,
    ST_NODEV     = 2'd1,
    ST_ADDR_NACK = 2'd2
  } stat_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_START,
    S_CHIP_W,
    S_ADDR,
    S_MID_STOP,
    S_MID_START,
    S_CHIP_R,
    S_WDATA,
    S_RDATA,
    S_RPUSH,
    S_STOP
  } state_e;
endpackage

// File: rtl/i2c_seq_chip_fold.sv
module i2c_seq_chip_fold #(
  parameter int ADDR_BYTES = 4,
  localparam int AW     = ADDR_BYTES * 8,
  localparam int ALEN_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic [6:0]        chip_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [ALEN_W-1:0] alen_i,
  input  logic [6:0]        mask_i,
  output logic [6:0]        chip_o
);
  logic [AW+7:0] shifted;
  logic          unused_hi;

  // pointer bits above the sent length land in the device address
  assign shifted   = {8'h00, addr_i} >> {alen_i, 3'b000};
  assign chip_o    = chip_i | (shifted[6:0] & mask_i);
  assign unused_hi = ^shifted[AW+7:7];
endmodule

// File: rtl/i2c_seq_addr_pick.sv
module i2c_seq_addr_pick #(
  parameter int ADDR_BYTES = 4,
  localparam int AW    = ADDR_BYTES * 8,
  localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       byte_o
);
  logic [7:0] lane [ADDR_BYTES];

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
    assign lane[g] = addr_i[g*8 +: 8];
  end

  assign byte_o = lane[idx_i];
endmodule

// File: rtl/i2c_seq_cnt.sv
module i2c_seq_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (ld_i)  q_o <= ld_val_i;
    else if (inc_i) q_o <= q_o + W'(1);
    else if (dec_i) q_o <= q_o - W'(1);
  end

  // byte and index counts never wrap (R2, R5, R8)
  assert_no_underflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !ld_i && !inc_i) |-> q_o != '0);
  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i) |-> q_o != '1);
endmodule

// File: rtl/i2c_xact_seq.sv
module i2c_xact_seq
  import i2c_seq_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int LEN_W      = 8
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               req_valid_i,
  output logic                               req_ready_o,
  input  logic [1:0]                         req_op_i,
  input  logic [6:0]                         req_chip_i,
  input  logic [ADDR_BYTES*8-1:0]            req_addr_i,
  input  logic [$clog2(ADDR_BYTES+1)-1:0]    req_alen_i,
  input  logic [LEN_W-1:0]                   req_len_i,
  input  logic                               req_rstart_i,
  input  logic [6:0]                         req_ovf_mask_i,
  input  logic                               wr_valid_i,
  input  logic [7:0]                         wr_data_i,
  output logic                               wr_ready_o,
  output logic                               rd_valid_o,
  output logic [7:0]                         rd_data_o,
  input  logic                               rd_ready_i,
  output logic                               cmd_valid_o,
  input  logic                               cmd_ready_i,
  output logic [1:0]                         cmd_o,
  output logic [7:0]                         cmd_byte_o,
  output logic                               cmd_ack_o,
  input  logic                               rsp_valid_i,
  input  logic                               rsp_nack_i,
  input  logic [7:0]                         rsp_data_i,
  output logic                               done_o,
  output logic [1:0]                         status_o,
  output logic [LEN_W-1:0]                   fail_cnt_o
);
  localparam int AW     = ADDR_BYTES * 8;
  localparam int ALEN_W = $clog2(ADDR_BYTES + 1);
  localparam int IDX_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  state_e              state_q, state_d;
  logic                wait_q;
  op_e                 op_q, op_c;
  logic [6:0]          chip_q, chip_f;
  logic [AW-1:0]       addr_q;
  logic [ALEN_W-1:0]   alen_q, alen_c;
  logic                rstart_q;
  stat_e               st_q, err_val;
  logic [7:0]          rd_q;
  logic                done_q;
  logic [1:0]          status_q;
  logic [LEN_W-1:0]    fail_q;

  logic                accept, fire, rsp, cmd_st;
  logic                idx_ld, idx_dec, rem_dec, fail_inc, err_set, fin;
  logic [IDX_W-1:0]    idx_q;
  logic [LEN_W-1:0]    rem_q, fail_cnt;
  logic [7:0]          addr_byte;
  logic                rem_last, rem_zero;
  cmd_e                cmd_d;
  logic [7:0]          byte_d;
  logic                ack_d;

  // request normalisation
  assign accept = (state_q == S_IDLE) && req_valid_i;
  assign alen_c = (req_alen_i > ALEN_W'(ADDR_BYTES)) ? ALEN_W'(ADDR_BYTES) : req_alen_i;
  assign op_c   = (req_op_i == 2'd3) ? OP_PROBE : op_e'(req_op_i);

  i2c_seq_chip_fold #(.ADDR_BYTES(ADDR_BYTES)) i_fold (
    .chip_i (req_chip_i),
    .addr_i (req_addr_i),
    .alen_i (alen_c),
    .mask_i (req_ovf_mask_i),
    .chip_o (chip_f)
  );

  i2c_seq_addr_pick #(.ADDR_BYTES(ADDR_BYTES)) i_pick (
    .addr_i (addr_q),
    .idx_i  (idx_q),
    .byte_o (addr_byte)
  );

  i2c_seq_cnt #(.W(IDX_W)) i_idx_cnt (
    .clk_i, .rst_ni,
    .ld_i     (idx_ld),
    .ld_val_i (IDX_W'(alen_q - ALEN_W'(1))),
    .inc_i    (1'b0),
    .dec_i    (idx_dec),
    .q_o      (idx_q)
  );

  i2c_seq_cnt #(.W(LEN_W)) i_rem_cnt (
    .clk_i, .rst_ni,
    .ld_i     (accept),
    .ld_val_i (req_len_i),
    .inc_i    (1'b0),
    .dec_i    (rem_dec),
    .q_o      (rem_q)
  );

  i2c_seq_cnt #(.W(LEN_W)) i_fail_cnt (
    .clk_i, .rst_ni,
    .ld_i     (accept),
    .ld_val_i ('0),
    .inc_i    (fail_inc),
    .dec_i    (1'b0),
    .q_o      (fail_cnt)
  );

  assign rem_last = (rem_q == LEN_W'(1));
  assign rem_zero = (rem_q == '0);

  // command decode
  always_comb begin
    cmd_d  = CMD_START;
    byte_d = 8'h00;
    ack_d  = 1'b0;
    cmd_st = 1'b1;
    unique case (state_q)
      S_START, S_MID_START: cmd_d = CMD_START;
      S_STOP, S_MID_STOP:   cmd_d = CMD_STOP;
      S_CHIP_W: begin cmd_d = CMD_WRITE; byte_d = {chip_q, 1'b0}; end
      S_CHIP_R: begin cmd_d = CMD_WRITE; byte_d = {chip_q, 1'b1}; end
      S_ADDR:   begin cmd_d = CMD_WRITE; byte_d = addr_byte; end
      S_WDATA:  begin cmd_d = CMD_WRITE; byte_d = wr_data_i; end
      S_RDATA:  begin cmd_d = CMD_READ;  ack_d  = rem_last; end
      default:  cmd_st = 1'b0;
    endcase
  end

  assign cmd_valid_o = cmd_st && !wait_q && (state_q != S_WDATA || wr_valid_i);
  assign cmd_o       = cmd_d;
  assign cmd_byte_o  = byte_d;
  assign cmd_ack_o   = ack_d;
  assign fire        = cmd_valid_o && cmd_ready_i;
  assign rsp         = wait_q && rsp_valid_i;
  assign wr_ready_o  = (state_q == S_WDATA) && fire;
  assign rd_valid_o  = (state_q == S_RPUSH);
  assign rd_data_o   = rd_q;
  assign req_ready_o = (state_q == S_IDLE);

  // sequencing
  always_comb begin
    state_d  = state_q;
    idx_ld   = 1'b0;
    idx_dec  = 1'b0;
    rem_dec  = 1'b0;
    fail_inc = 1'b0;
    err_set  = 1'b0;
    err_val  = ST_OK;
    fin      = 1'b0;
    unique case (state_q)
      S_IDLE: if (req_valid_i) state_d = S_START;
      S_START: if (rsp)
        state_d = (op_q == OP_READ && alen_q == '0) ? S_CHIP_R : S_CHIP_W;
      S_CHIP_W: if (rsp) begin
        if (rsp_nack_i) begin
          err_set = 1'b1; err_val = ST_NODEV; state_d = S_STOP;
        end else if (op_q == OP_PROBE) begin
          state_d = S_STOP;
        end else if (alen_q != '0) begin
          idx_ld = 1'b1; state_d = S_ADDR;
        end else begin
          state_d = rem_zero ? S_STOP : S_WDATA;
        end
      end
      S_ADDR: if (rsp) begin
        if (rsp_nack_i) begin
          err_set = 1'b1; err_val = ST_ADDR_NACK; state_d = S_STOP;
        end else if (idx_q != '0) begin
          idx_dec = 1'b1;
        end else if (op_q == OP_WRITE) begin
          state_d = rem_zero ? S_STOP : S_WDATA;
        end else begin
          state_d = rstart_q ? S_MID_START : S_MID_STOP;
        end
      end
      S_MID_STOP:  if (rsp) state_d = S_MID_START;
      S_MID_START: if (rsp) state_d = S_CHIP_R;
      S_CHIP_R: if (rsp) begin
        if (rsp_nack_i) begin
          err_set = 1'b1; err_val = ST_NODEV; state_d = S_STOP;
        end else begin
          state_d = rem_zero ? S_STOP : S_RDATA;
        end
      end
      S_WDATA: if (rsp) begin
        fail_inc = rsp_nack_i;
        rem_dec  = 1'b1;
        state_d  = rem_last ? S_STOP : S_WDATA;
      end
      S_RDATA: if (rsp) state_d = S_RPUSH;
      S_RPUSH: if (rd_ready_i) begin
        rem_dec = 1'b1;
        state_d = rem_last ? S_STOP : S_RDATA;
      end
      S_STOP: if (rsp) begin
        fin = 1'b1; state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      wait_q   <= 1'b0;
      op_q     <= OP_WRITE;
      chip_q   <= '0;
      addr_q   <= '0;
      alen_q   <= '0;
      rstart_q <= 1'b0;
      st_q     <= ST_OK;
      rd_q     <= '0;
      done_q   <= 1'b0;
      status_q <= '0;
      fail_q   <= '0;
    end else begin
      state_q <= state_d;
      if (fire)     wait_q <= 1'b1;
      else if (rsp) wait_q <= 1'b0;
      if (accept) begin
        op_q     <= op_c;
        chip_q   <= chip_f;
        addr_q   <= req_addr_i;
        alen_q   <= alen_c;
        rstart_q <= req_rstart_i;
        st_q     <= ST_OK;
      end else if (err_set) begin
        st_q <= err_val;
      end
      if (state_q == S_RDATA && rsp) rd_q <= rsp_data_i;
      done_q <= fin;
      if (fin) begin
        status_q <= st_q;
        fail_q   <= fail_cnt;
      end
    end
  end

  assign done_o     = done_q;
  assign status_o   = status_q;
  assign fail_cnt_o = fail_q;

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_status_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({status_o, fail_cnt_o}) |-> done_o);
  assert_rd_only_in_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> op_q == OP_READ);
  assert_wr_only_in_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ready_o |-> op_q == OP_WRITE);
  assert_probe_no_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && op_q == OP_PROBE) |-> cmd_o != CMD_READ);
  assert_port_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({req_ready_o, cmd_valid_o, rd_valid_o}));
endmodule

// File: tb/test_i2c_xact_seq.sv
module test_i2c_xact_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [1:0]  req_op_i = '0;
  logic [6:0]  req_chip_i = '0;
  logic [31:0] req_addr_i = '0;
  logic [2:0]  req_alen_i = '0;
  logic [7:0]  req_len_i = '0;
  logic        req_rstart_i = 1'b0;
  logic [6:0]  req_ovf_mask_i = '0;
  logic        wr_valid_i = 1'b0;
  logic [7:0]  wr_data_i = '0;
  logic        wr_ready_o;
  logic        rd_valid_o;
  logic [7:0]  rd_data_o;
  logic        rd_ready_i = 1'b0;
  logic        cmd_valid_o;
  logic        cmd_ready_i = 1'b0;
  logic [1:0]  cmd_o;
  logic [7:0]  cmd_byte_o;
  logic        cmd_ack_o;
  logic        rsp_valid_i = 1'b0;
  logic        rsp_nack_i = 1'b0;
  logic [7:0]  rsp_data_i = '0;
  logic        done_o;
  logic [1:0]  status_o;
  logic [7:0]  fail_cnt_o;

  always #4 clk_i = ~clk_i;

  i2c_xact_seq #(.ADDR_BYTES(4), .LEN_W(8)) i_i2c_xact_seq (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;

  // expected command stream and read data
  logic [1:0] xc[$];
  logic [7:0] xb[$];
  bit         xa[$];
  string      xt[$];
  logic [7:0] xrd[$];
  logic [7:0] wq[$];

  // bit-engine model state
  logic [63:0] nmask = '0;
  int  eng_wo = 0, eng_ro = 0, pend = 0;
  bit  p_nack = 1'b0;
  logic [7:0] p_data = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic px(input logic [1:0] c, input logic [7:0] b, input bit a, input string t);
    xc.push_back(c); xb.push_back(b); xa.push_back(a); xt.push_back(t);
  endtask

  // engine and sinks, all driven at the falling edge
  initial begin
    forever begin
      @(negedge clk_i);
      cyc++;
      rsp_valid_i = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          rsp_valid_i = 1'b1; rsp_nack_i = p_nack; rsp_data_i = p_data;
        end
      end
      cmd_ready_i = (cyc % 4) != 3;
      rd_ready_i  = (cyc % 3) != 1;
      wr_valid_i  = wq.size() > 0;
      wr_data_i   = (wq.size() > 0) ? wq[0] : 8'h00;
      #1;
      if (cmd_valid_o && cmd_ready_i) begin
        if (xc.size() == 0) begin
          chk(1'b0, "R6", "unexpected command", {cmd_o, cmd_byte_o}, 0);
        end else begin
          logic [1:0] ec; logic [7:0] eb; bit ea; string et; bit ok;
          ec = xc.pop_front(); eb = xb.pop_front(); ea = xa.pop_front(); et = xt.pop_front();
          ok = (cmd_o == ec) && (ec != 2'd2 || cmd_byte_o == eb) && (ec != 2'd3 || cmd_ack_o == ea);
          chk(ok, et, "command {code,byte,ack}", {cmd_o, cmd_byte_o, cmd_ack_o}, {ec, eb, ea});
        end
        p_nack = 1'b0;
        if (cmd_o == 2'd2) begin p_nack = nmask[eng_wo]; eng_wo++; end
        if (cmd_o == 2'd3) begin p_data = 8'h3C + 8'(eng_ro * 17); eng_ro++; end
        pend = 2;
        if (wr_ready_o && wq.size() > 0) void'(wq.pop_front());
      end
      if (rd_valid_o && rd_ready_i) begin
        logic [7:0] er;
        er = (xrd.size() > 0) ? xrd.pop_front() : 8'hxx;
        chk(rd_data_o === er, "R5", "read byte", rd_data_o, er);
      end
    end
  end

  task automatic run_txn(input logic [1:0] op, input logic [6:0] chip, input logic [31:0] addr,
                         input int alen, input int len, input bit rs, input logic [6:0] mask,
                         input logic [63:0] nm, input string tag);
    logic [39:0] ext; logic [6:0] fc; int wo, st, fails; bit do_read; bit seen;
    logic [1:0] st_hold;
    ext = {8'h00, addr} >> (8 * alen);
    fc = chip | (ext[6:0] & mask);
    wo = 0; st = 0; fails = 0;
    do_read = (op == 2'd1 && alen == 0);
    px(2'd0, 8'h00, 1'b0, "R1");
    if (!do_read) begin
      px(2'd2, {fc, 1'b0}, 1'b0, (mask != 0) ? "R10" : "R1");
      if (nm[wo]) begin
        st = 1; px(2'd1, 8'h00, 1'b0, (op >= 2'd2) ? "R9" : "R6");
      end else begin
        wo++;
        if (op >= 2'd2) px(2'd1, 8'h00, 1'b0, "R9");
        else begin
          for (int i = alen - 1; i >= 0 && st == 0; i--) begin
            px(2'd2, addr[8*i +: 8], 1'b0, "R2");
            if (nm[wo]) begin st = 2; px(2'd1, 8'h00, 1'b0, "R7"); end
            wo++;
          end
          if (st == 0) begin
            if (op == 2'd0) begin
              for (int j = 0; j < len; j++) begin
                logic [7:0] d;
                d = 8'hA5 ^ 8'(j * 29);
                wq.push_back(d);
                px(2'd2, d, 1'b0, "R8");
                if (nm[wo]) fails++;
                wo++;
              end
              px(2'd1, 8'h00, 1'b0, "R8");
            end else begin
              if (!rs) px(2'd1, 8'h00, 1'b0, "R4");
              px(2'd0, 8'h00, 1'b0, "R4");
              do_read = 1'b1;
            end
          end
        end
      end
    end
    if (do_read) begin
      px(2'd2, {fc, 1'b1}, 1'b0, (alen == 0) ? "R3" : "R1");
      if (nm[wo]) begin
        st = 1; px(2'd1, 8'h00, 1'b0, "R6");
      end else begin
        for (int j = 0; j < len; j++) begin
          px(2'd3, 8'h00, (j == len - 1), "R5");
          xrd.push_back(8'h3C + 8'(j * 17));
        end
        px(2'd1, 8'h00, 1'b0, "R5");
      end
    end

    nmask = nm; eng_wo = 0; eng_ro = 0;
    @(negedge clk_i);
    req_op_i = op; req_chip_i = chip; req_addr_i = addr; req_alen_i = 3'(alen);
    req_len_i = 8'(len); req_rstart_i = rs; req_ovf_mask_i = mask; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    seen = 1'b0;
    for (int t = 0; t < 20000 && !seen; t++) begin
      @(negedge clk_i);
      #2;
      seen = done_o;
    end
    chk(seen, tag, "completion pulse (watchdog)", seen, 1);
    chk(status_o == 2'(st), tag, "status", status_o, st);
    chk(fail_cnt_o == 8'(fails), "R8", "failure count", fail_cnt_o, fails);
    chk(xc.size() == 0, tag, "commands left unissued", xc.size(), 0);
    chk(xrd.size() == 0, "R5", "read bytes left undelivered", xrd.size(), 0);
    chk(wq.size() == 0, "R8", "write bytes left untaken", wq.size(), 0);
    xc.delete(); xb.delete(); xa.delete(); xt.delete(); xrd.delete(); wq.delete();
    st_hold = status_o;
    repeat (3) @(negedge clk_i);
    #2;
    chk(done_o == 1'b0, "R11", "pulse length", done_o, 0);
    chk(status_o == st_hold, "R11", "status hold", status_o, st_hold);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #2;
    chk(req_ready_o == 1'b1, "R12", "idle ready", req_ready_o, 1);
    chk(cmd_valid_o == 1'b0 && rd_valid_o == 1'b0, "R12", "no traffic", {cmd_valid_o, rd_valid_o}, 0);
    chk(done_o == 1'b0 && status_o == 2'd0 && fail_cnt_o == 8'd0, "R12", "status reset",
        {done_o, status_o, fail_cnt_o}, 0);

    run_txn(2'd0, 7'h50, 32'h0000_1234, 2, 3, 1'b0, 7'h00, 64'h0, "R8");   // plain write
    run_txn(2'd0, 7'h21, 32'h0000_0077, 1, 4, 1'b0, 7'h00, 64'h14, "R8");  // data misses
    run_txn(2'd1, 7'h50, 32'h0000_BEEF, 2, 3, 1'b0, 7'h00, 64'h0, "R4");   // stop+start
    run_txn(2'd1, 7'h33, 32'h0000_0042, 1, 1, 1'b1, 7'h00, 64'h0, "R4");   // repeated start
    run_txn(2'd1, 7'h68, 32'h0000_0000, 0, 2, 1'b0, 7'h00, 64'h0, "R3");   // no pointer
    run_txn(2'd2, 7'h50, 32'h0, 0, 0, 1'b0, 7'h00, 64'h0, "R9");          // present
    run_txn(2'd2, 7'h51, 32'h0, 0, 0, 1'b0, 7'h00, 64'h1, "R9");          // absent
    run_txn(2'd3, 7'h52, 32'h0, 0, 0, 1'b0, 7'h00, 64'h0, "R9");          // code 3 probes
    run_txn(2'd0, 7'h10, 32'h0000_0102, 2, 2, 1'b0, 7'h00, 64'h1, "R6");   // no device
    run_txn(2'd0, 7'h11, 32'h00AB_CDEF, 3, 2, 1'b0, 7'h00, 64'h4, "R7");   // pointer miss
    run_txn(2'd1, 7'h12, 32'h0000_0005, 1, 2, 1'b0, 7'h00, 64'h4, "R6");   // read-phase miss
    run_txn(2'd0, 7'h50, 32'h0000_0345, 1, 2, 1'b0, 7'h07, 64'h0, "R10");  // overflow fold
    run_txn(2'd1, 7'h50, 32'h0000_06A0, 1, 2, 1'b1, 7'h07, 64'h0, "R10");
    run_txn(2'd0, 7'h40, 32'hFFEE_DDCC, 4, 1, 1'b0, 7'h7F, 64'h0, "R2");   // full pointer
    run_txn(2'd0, 7'h40, 32'h0000_0009, 1, 0, 1'b0, 7'h00, 64'h0, "R8");   // no payload
    summary();
  end
endmodule